// File: doc/BRIEF.md
# Receive Descriptor Ring Consumer

This block walks the head of a small ring of receive descriptors that a DMA engine fills. Each poll looks at the 32-bit status word of the head entry, as presented by descriptor memory for the current head index. The block decides whether software may touch the entry yet. When it may, the block sorts the entry into one of three classes: a good single-buffer frame, a piece of an oversized frame that spans several buffers, or a fatal receive error.

A poll either peeks or takes. A peek only reports that a frame is waiting and changes nothing. A take consumes the entry. For a good frame, a take reports the payload length without the CRC, writes the status word back with only the ownership bit set so the hardware gets the entry again, and advances the head. A piece of an oversized frame is skipped: the head advances and a warning flag is raised for suspicious pieces. A fatal error raises a one-cycle reset request, returns the head to entry 0 and reports no frame. Moving frame data and arbitrating for descriptor memory are left to surrounding logic.

Top module: `rx_desc_walker`

## Requirements
- R1: After reset the head index is 0, and `rsp_valid`, `frame_ready`, `rsp_kind`, `frame_len`, `frag_warn`, `fatal_cause`, `reset_req` and `wb_en` are all 0.
- R2: When `head_status[31]` is 1, a poll of either kind gives a response with `frame_ready`=0 and `rsp_kind`=0. The head does not move and no write-back occurs.
- R3: A peek (`poll_take`=0) of an entry with `head_status[31]`=0 gives `frame_ready`=1 and `rsp_kind`=0. The head does not move, and there is no write-back and no reset request.
- R4: A take of an entry with bit 31 clear and `(status & 0x38008300) == 0x00000300` is a good frame. The response has `frame_ready`=1 and `rsp_kind`=1.
- R5: For a good frame, `frame_len` is status bits 26:16 minus 4, taken modulo 2048 (11 bits). For every other response it is 0.
- R6: A good frame causes one write-back in its response cycle: `wb_en`=1, `wb_idx` = the head index that was polled, and `wb_data` = 0x80000000. No other response writes back, and `wb_data` is 0 whenever `wb_en` is 0.
- R7: A take of an entry with bit 31 clear and `(status & 0x38000300) != 0x00000300` is a fragment. The response has `rsp_kind`=2 and `frame_ready`=0, the head advances, there is no write-back, and `frag_warn` is 1 exactly when status bits 15:0 differ from 0x7FFF.
- R8: A take of an entry that is neither good nor a fragment (the fatal-error case, bit 15 set) gives `rsp_kind`=3, `frame_ready`=0 and `reset_req`=1 for that one cycle, and the head returns to 0. `fatal_cause[2]` is set when any of status bits 11, 7 and 4 (mask 0x0890) is set, `fatal_cause[1]` for mask 0x004C and `fatal_cause[0]` for bit 1. `fatal_cause` is 0 on all other responses.
- R9: The head advances by one after every good or fragment take and wraps from `RING_DEPTH-1` to 0. `RING_DEPTH` is a power of two, 2 by default.
- R10: Every response appears in the cycle after the clock edge that samples `poll_req`. In a cycle with no response, all response outputs and `wb_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| poll_req | input | 1 | Poll the head entry in this cycle |
| poll_take | input | 1 | 1 = take (consume), 0 = peek |
| head_status | input | 32 | Status word of the entry at `head_idx` |
| head_idx | output | $clog2(RING_DEPTH) | Current head entry index |
| rsp_valid | output | 1 | Response to the previous poll |
| frame_ready | output | 1 | A frame is available (peek) or was taken |
| rsp_kind | output | 2 | 0 none, 1 good, 2 fragment, 3 fatal |
| frame_len | output | 11 | Payload length without the CRC |
| frag_warn | output | 1 | Fragment has unexpected low half-word |
| fatal_cause | output | 3 | {length, framing, CRC} error flags |
| reset_req | output | 1 | One-cycle request to reset the receiver |
| wb_en | output | 1 | Write `wb_data` to descriptor `wb_idx` |
| wb_idx | output | $clog2(RING_DEPTH) | Descriptor index to write back |
| wb_data | output | 32 | Status word returned to the hardware |

## Verification
Every result of a poll, including the new head index, the write-back and the reset request, becomes visible exactly one clock edge after the edge that samples the poll. The bench drives each poll on the falling edge and compares all outputs with its behavioural model 1 ns after the next rising edge. The model compares on every clock, including cycles with no poll. This catches a response that comes one cycle early or late, as well as a pulse that lasts longer than one cycle.

// File: rtl/rx_desc_walker.sv
module rx_desc_walker #(
  parameter int RING_DEPTH = 2,
  localparam int IDX_W = (RING_DEPTH > 2) ? $clog2(RING_DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_req,
  input  logic             poll_take,
  input  logic [31:0]      head_status,
  output logic [IDX_W-1:0] head_idx,
  output logic             rsp_valid,
  output logic             frame_ready,
  output logic [1:0]       rsp_kind,
  output logic [10:0]      frame_len,
  output logic             frag_warn,
  output logic [2:0]       fatal_cause,
  output logic             reset_req,
  output logic             wb_en,
  output logic [IDX_W-1:0] wb_idx,
  output logic [31:0]      wb_data
);

  localparam logic [31:0] OWN_BIT    = 32'h8000_0000;
  localparam logic [31:0] GOOD_MASK  = 32'h3800_8300;
  localparam logic [31:0] SPAN_MASK  = 32'h3800_0300;
  localparam logic [31:0] WHOLE_PKT  = 32'h0000_0300;
  localparam logic [1:0]  K_NONE = 2'd0, K_GOOD = 2'd1, K_FRAG = 2'd2, K_FATAL = 2'd3;

  logic hw_owned, is_good, is_single, is_frag, is_fatal, take_ok;
  assign hw_owned  = head_status[31];
  assign is_good   = (head_status & GOOD_MASK) == WHOLE_PKT;
  assign is_single = (head_status & SPAN_MASK) == WHOLE_PKT;
  assign is_frag   = !is_single;
  assign is_fatal  = is_single && !is_good;
  assign take_ok   = poll_req && poll_take && !hw_owned;

  logic [10:0] len_now;
  assign len_now = head_status[26:16] - 11'd4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_idx    <= '0;
      rsp_valid   <= 1'b0;
      frame_ready <= 1'b0;
      rsp_kind    <= K_NONE;
      frame_len   <= '0;
      frag_warn   <= 1'b0;
      fatal_cause <= '0;
      reset_req   <= 1'b0;
      wb_en       <= 1'b0;
      wb_idx      <= '0;
    end else begin
      rsp_valid   <= poll_req;
      frame_ready <= poll_req && !hw_owned && (!poll_take || is_good);
      rsp_kind    <= K_NONE;
      frame_len   <= '0;
      frag_warn   <= 1'b0;
      fatal_cause <= '0;
      reset_req   <= 1'b0;
      wb_en       <= 1'b0;
      wb_idx      <= '0;
      if (take_ok) begin
        if (is_good) begin
          rsp_kind  <= K_GOOD;
          frame_len <= len_now;
          wb_en     <= 1'b1;
          wb_idx    <= head_idx;
          head_idx  <= head_idx + 1'b1;
        end else if (is_frag) begin
          rsp_kind  <= K_FRAG;
          frag_warn <= head_status[15:0] != 16'h7FFF;
          head_idx  <= head_idx + 1'b1;
        end else begin
          rsp_kind    <= K_FATAL;
          fatal_cause <= {|(head_status & 32'h0890), |(head_status & 32'h004C), head_status[1]};
          reset_req   <= 1'b1;
          head_idx    <= '0;
        end
      end
    end
  end

  assign wb_data = wb_en ? OWN_BIT : 32'h0;

  // R2
  owned_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req && hw_owned |=> rsp_valid && !frame_ready && rsp_kind == K_NONE && !wb_en && $stable(head_idx));

  // R3
  peek_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_req && !poll_take |=> $stable(head_idx) && !wb_en && !reset_req);

  // R6
  wb_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> rsp_valid && frame_ready && rsp_kind == K_GOOD && wb_idx == $past(head_idx));

  // R8
  fatal_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok && is_fatal |=> reset_req && head_idx == '0 && !frame_ready);

  // R9
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_ok && !is_fatal |=> head_idx == IDX_W'($past(head_idx) + 1'b1));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !frame_ready && rsp_kind == K_NONE && !reset_req && !wb_en && frame_len == '0);

endmodule

// File: tb/rx_desc_walker_test.sv
module rx_desc_walker_test;
  localparam int D = 2;
  localparam int IW = 1;

  logic clk = 0, rst_n = 0, poll_req = 0, poll_take = 0;
  logic [31:0] head_status;
  logic [IW-1:0] head_idx, wb_idx;
  logic rsp_valid, frame_ready, frag_warn, reset_req, wb_en;
  logic [1:0] rsp_kind;
  logic [10:0] frame_len;
  logic [2:0] fatal_cause;
  logic [31:0] wb_data;

  logic [31:0] mem [D];
  int checks = 0, errors = 0;
  int mh = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign head_status = mem[head_idx];

  rx_desc_walker #(.RING_DEPTH(D)) uut (
    .clk(clk), .rst_n(rst_n), .poll_req(poll_req), .poll_take(poll_take),
    .head_status(head_status), .head_idx(head_idx), .rsp_valid(rsp_valid),
    .frame_ready(frame_ready), .rsp_kind(rsp_kind), .frame_len(frame_len),
    .frag_warn(frag_warn), .fatal_cause(fatal_cause), .reset_req(reset_req),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit t, input string req);
    bit e_rv, e_fr, e_fw, e_rr, e_wb;
    int e_kind, e_len, e_fc, e_wi, old;
    logic [31:0] s;
    @(negedge clk);
    poll_req = v; poll_take = t;
    e_rv = v; e_fr = 0; e_fw = 0; e_rr = 0; e_wb = 0;
    e_kind = 0; e_len = 0; e_fc = 0; e_wi = 0;
    old = mh; s = mem[mh];
    if (v && !s[31]) begin
      if (!t) e_fr = 1;
      else if ((s & 32'h38008300) == 32'h300) begin
        e_fr = 1; e_kind = 1; e_len = (((s >> 16) & 32'h7ff) + 2048 - 4) % 2048;
        e_wb = 1; e_wi = old;
      end else if ((s & 32'h38000300) != 32'h300) begin
        e_kind = 2; e_fw = (s[15:0] != 16'h7FFF);
      end else begin
        e_kind = 3; e_rr = 1;
        e_fc = ((s & 32'h0890) != 0 ? 4 : 0) + ((s & 32'h004C) != 0 ? 2 : 0) + (s[1] ? 1 : 0);
      end
    end
    @(posedge clk); #1;
    if (e_wb) mem[old] = 32'h8000_0000;
    if (e_kind == 1 || e_kind == 2) mh = (mh + 1) % D;
    if (e_kind == 3) mh = 0;
    chk({req, " R10 rsp_valid"}, rsp_valid, e_rv);
    chk({req, " R2/R3 frame_ready"}, frame_ready, e_fr);
    chk({req, " R4 rsp_kind"}, rsp_kind, e_kind);
    chk({req, " R5 frame_len"}, frame_len, e_len);
    chk({req, " R7 frag_warn"}, frag_warn, e_fw);
    chk({req, " R8 fatal_cause"}, fatal_cause, e_fc);
    chk({req, " R8 reset_req"}, reset_req, e_rr);
    chk({req, " R6 wb_en"}, wb_en, e_wb);
    chk({req, " R6 wb_idx"}, wb_idx, e_wi);
    chk({req, " R6 wb_data"}, wb_data, e_wb ? 32'h8000_0000 : 32'h0);
    chk({req, " R9 head_idx"}, head_idx, mh);
    poll_req = 0;
  endtask

  function automatic logic [31:0] good(input int fld);
    return 32'h0000_0300 | (32'(fld & 'h7ff) << 16);
  endfunction

  initial begin
    for (int i = 0; i < D; i++) mem[i] = 32'h8000_0000;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 head_idx", head_idx, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 reset_req", reset_req, 0);
    chk("R1 wb_en", wb_en, 0);
    chk("R1 frame_ready", frame_ready, 0);
    @(negedge clk); rst_n = 1;
    step(0, 0, "R10 idle");
    step(1, 1, "R2 owned take");
    step(1, 0, "R2 owned peek");
    mem[0] = good(68);
    step(1, 0, "R3 peek");
    step(1, 0, "R3 peek again");
    step(1, 1, "R4 good take e0");
    step(0, 0, "R10 idle after");
    mem[1] = good(1518) | 32'h0000_0400;
    step(1, 1, "R9 good take e1 wrap");
    step(1, 1, "R2 returned entry");
    mem[0] = 32'h1000_0300 | 32'h7FFF;
    step(1, 1, "R7 fragment quiet");
    mem[1] = 32'h2000_0000 | 32'h1234;
    step(1, 1, "R7 fragment warn");
    mem[0] = 32'h0800_8300 | 32'h0890;
    step(1, 1, "R7 fragment with bit15");
    mem[1] = 32'h0000_8300 | 32'h0002;
    step(1, 1, "R8 fatal crc");
    step(0, 0, "R8 pulse ends");
    mem[0] = good(2);
    step(1, 1, "R5 short length wrap");
    mem[1] = 32'h0000_8300 | 32'h0048;
    step(1, 1, "R8 fatal framing");
    mem[0] = 32'h0000_8300 | 32'h0810 | 32'h0004;
    step(1, 1, "R8 fatal len+frm");
    mem[0] = good(4);
    step(1, 1, "R5 zero length");
    mem[1] = 32'h4000_0000 | good(100);
    step(1, 0, "R3 peek other pattern");
    step(1, 1, "R4 good with bit30");
    for (int k = 0; k < 40; k++) begin
      mem[mh] = (k % 4 == 3) ? (32'h0000_8300 | 32'(k & 'h8de)) :
                (k % 4 == 2) ? (32'h1800_0100 | 32'(k)) : good(60 + k * 37);
      step(1, (k % 5) != 0, "R9 sweep");
      step(k % 3 == 0, 1, "R10 sweep");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule